// File: doc/BRIEF.md
# Fractional Clock Divider with Period Strobe

This block takes a fast free-running clock and derives a slower clock from it, together with a strobe. The strobe is high for exactly one fast-clock cycle at the start of every slow period. Both frequencies are given in hertz as parameters. The ratio between them need not be a whole number.

In fractional mode, a wide phase accumulator advances by a fixed step on every input cycle. The top bit of the accumulator is the output clock, so the long-run output frequency tracks the requested value closely. Individual periods differ by one input cycle.

In integer mode, the ratio is rounded to a whole number of input cycles. Every period then has exactly that length, with a fixed high/low split. Logic that runs on the fast clock uses the strobe as a clock enable. A typical setting makes a 3.072 MHz audio bit clock from a 100 MHz system clock. An output frequency above half the input frequency is rejected when the design is elaborated.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `clk_out` and `strobe` are both 0 after that edge.
- R2: In fractional mode, the step is STEP = round(OUT_HZ × 2^ACC_W / IN_HZ). After j rising edges following reset, the number of strobes seen is floor((j × STEP + 2^(ACC_W-1)) / 2^ACC_W).
- R3: In fractional mode, after the j-th edge following reset, `clk_out` equals bit ACC_W-1 of (j × STEP) mod 2^ACC_W. The accumulator starts at zero.
- R4: `strobe` is 1 exactly in those cycles where `clk_out` has just gone from 0 to 1. It is never high in two consecutive cycles.
- R5: In integer mode, with N = round(IN_HZ / OUT_HZ), the first strobe comes after the first edge following reset. Strobes then repeat exactly every N cycles.
- R6: In integer mode, `clk_out` is high for the first ceil(N/2) cycles of each period and low for the remaining floor(N/2) cycles.
- R7: With OUT_HZ equal to IN_HZ/2, `clk_out` toggles on every edge in either mode. It is high, with `strobe` high, after odd-numbered edges following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_out | output | 1 | Divided clock, nominal 50/50 duty |
| strobe | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The fractional mode is run at a non-integer ratio of about 32.55. A cycle-by-cycle comparison against the accumulator formula separates a correct step and top-bit choice from an off-by-one or truncated step. A strobe count over a long window catches errors in the rate alone. The integer mode at the same frequencies checks that every period is exactly 33 cycles with a 17/16 split, which a fractional core would not produce. The half-rate setting, in both modes, tests the tightest boundary, where strobes come every second cycle.

// File: rtl/fdiv_pkg.sv
// Package with elaboration-time arithmetic for the divider.
// Assumes frequencies fit well below 2^24 Hz times 2^40 in 64 bits.
package fdiv_pkg;

    // Rounded phase increment for an accumulator of width w.
    function automatic longint unsigned phase_step(longint unsigned in_hz,
                                                   longint unsigned out_hz,
                                                   int w);
        return ((out_hz << w) + (in_hz / 2)) / in_hz;
    endfunction

    // Rounded whole-cycle period for integer mode.
    function automatic longint unsigned whole_period(longint unsigned in_hz,
                                                     longint unsigned out_hz);
        return (in_hz + (out_hz / 2)) / out_hz;
    endfunction

endpackage

// File: rtl/frac_accum.sv
// Fractional phase accumulator core.
// Adds STEP every cycle. It reports the top bit the accumulator will hold
// after the coming edge. Assumes STEP <= 2^(ACC_W-1).
module frac_accum #(
    parameter int              ACC_W = 32,
    parameter logic [ACC_W-1:0] STEP = '0
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_hi_next
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;

    // Next phase value.
    always_comb acc_next = acc + STEP;

    // Phase register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_next;
    end

    assign phase_hi_next = acc_next[ACC_W-1];

    // The step never exceeds half a turn, so the top bit cannot stay high
    // across two wraps: a set top bit falls or stays, never skips a low phase.
    assert_halfturn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[ACC_W-1] && $past(acc[ACC_W-1]) && rst_n && $past(rst_n))
            |-> (acc >= $past(acc)));
endmodule

// File: rtl/int_count.sv
// Integer-mode core: a modulo-PERIOD counter.
// The phase is high for the first ceil(PERIOD/2) counts of each period.
// Assumes PERIOD >= 2. Reset parks the counter at the last count, so the
// first edge after reset begins a period.
module int_count #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_hi_next
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int HI    = PERIOD - (PERIOD / 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;

    // Next count, wrapping at the period.
    always_comb cnt_next = (cnt == LAST) ? '0 : cnt + 1'b1;

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= LAST;
        else        cnt <= cnt_next;
    end

    assign phase_hi_next = (32'(cnt_next) < HI);

    // Period boundary: the last count is always followed by count zero.
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/clk_out_stage.sv
// Output register stage shared by both cores.
// Registers the phase into the output clock. It raises the strobe on the
// edge where that clock goes from low to high.
module clk_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_hi_next,
    output logic clk_q,
    output logic stb_q
);
    // Clock and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            clk_q <= phase_hi_next;
            stb_q <= phase_hi_next & ~clk_q;
        end
    end

    // The strobe marks a fresh rising clock.
    assert_stb_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (clk_q && !$past(clk_q)));

    // Every rising clock carries a strobe.
    assert_rise_has_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> stb_q);

    // The strobe lasts a single cycle.
    assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // Outputs stay low in the cycle after a reset edge.
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!clk_q && !stb_q));
endmodule

// File: rtl/frac_clk_div.sv
// Top of the divider. A parameter picks the fractional accumulator or the
// whole-cycle counter, and both feed the shared output stage.
// Assumes OUT_HZ <= IN_HZ/2, which is checked at elaboration, and
// 32 <= ACC_W <= 40.
module frac_clk_div #(
    parameter longint unsigned IN_HZ      = 100_000_000,
    parameter longint unsigned OUT_HZ     = 3_072_000,
    parameter bit              FRACTIONAL = 1'b1,
    parameter int              ACC_W      = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_out,
    output logic strobe
);
    import fdiv_pkg::*;

    localparam longint unsigned STEP_L = phase_step(IN_HZ, OUT_HZ, ACC_W);
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(STEP_L);
    localparam int PERIOD = int'(whole_period(IN_HZ, OUT_HZ));

    logic phase_hi_next;

    // Reject settings the cores cannot honour.
    if ((OUT_HZ * 2) > IN_HZ || OUT_HZ == 0) begin : g_bad_ratio
        $error("frac_clk_div: output frequency must be nonzero and at most half the input");
    end
    if (ACC_W < 32 || ACC_W > 40) begin : g_bad_width
        $error("frac_clk_div: accumulator width must be 32 to 40");
    end

    // Pick the phase source.
    if (FRACTIONAL) begin : g_frac
        frac_accum #(.ACC_W(ACC_W), .STEP(STEP)) u_core (
            .clk           (clk),
            .rst_n         (rst_n),
            .phase_hi_next (phase_hi_next)
        );
    end else begin : g_int
        int_count #(.PERIOD(PERIOD)) u_core (
            .clk           (clk),
            .rst_n         (rst_n),
            .phase_hi_next (phase_hi_next)
        );
    end

    clk_out_stage u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_hi_next (phase_hi_next),
        .clk_q         (clk_out),
        .stb_q         (strobe)
    );
endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
    localparam longint unsigned IN_HZ  = 100_000_000;
    localparam longint unsigned OUT_HZ = 3_072_000;
    localparam longint unsigned STEP   = ((OUT_HZ << 32) + IN_HZ / 2) / IN_HZ;
    localparam int N  = int'((IN_HZ + OUT_HZ / 2) / OUT_HZ);
    localparam int HI = (N + 1) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_clk, f_stb, i_clk, i_stb, fh_clk, fh_stb, ih_clk, ih_stb;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    frac_clk_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_HZ), .FRACTIONAL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .clk_out(f_clk), .strobe(f_stb));
    frac_clk_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_HZ), .FRACTIONAL(1'b0)) uut_int (
        .clk(clk), .rst_n(rst_n), .clk_out(i_clk), .strobe(i_stb));
    frac_clk_div #(.IN_HZ(IN_HZ), .OUT_HZ(IN_HZ / 2), .FRACTIONAL(1'b1)) uut_fhalf (
        .clk(clk), .rst_n(rst_n), .clk_out(fh_clk), .strobe(fh_stb));
    frac_clk_div #(.IN_HZ(IN_HZ), .OUT_HZ(IN_HZ / 2), .FRACTIONAL(1'b0)) uut_ihalf (
        .clk(clk), .rst_n(rst_n), .clk_out(ih_clk), .strobe(ih_stb));

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of the fractional top bit after edge j (from R3).
    function automatic bit frac_bit(longint unsigned j);
        return bit'(((j * STEP) >> 31) & 64'd1);
    endfunction

    // Hold reset for a few edges, release it between edges.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 clocks low in reset", {f_clk, i_clk, fh_clk, ih_clk}, 0);
        check("R1 strobes low in reset", {f_stb, i_stb, fh_stb, ih_stb}, 0);
    endtask

    task automatic test_frac_rate();
        int cnt_a = 0;
        int cnt_b = 0;
        do_reset();
        for (int j = 1; j <= 3000; j++) begin
            @(negedge clk);
            if (f_stb) cnt_b++;
            if (j <= 977 && f_stb) cnt_a++;
        end
        check("R2 strobes in 977 cycles", cnt_a,
              longint'((977 * STEP + 64'h8000_0000) >> 32));
        check("R2 strobes in 3000 cycles", cnt_b,
              longint'((3000 * STEP + 64'h8000_0000) >> 32));
    endtask

    task automatic test_frac_shape();
        int mis_clk = 0;
        int highs = 0;
        int exp_highs = 0;
        int mis_stb = 0;
        int doubles = 0;
        bit prev_c = 1'b0;
        bit prev_s = 1'b0;
        do_reset();
        for (int j = 1; j <= 2000; j++) begin
            @(negedge clk);
            if (f_clk != frac_bit(longint'(j))) mis_clk++;
            if (f_clk) highs++;
            if (frac_bit(longint'(j))) exp_highs++;
            if (f_stb != (f_clk && !prev_c)) mis_stb++;
            if (f_stb && prev_s) doubles++;
            prev_c = f_clk;
            prev_s = f_stb;
        end
        check("R3 clock bit mismatches", mis_clk, 0);
        check("R3 high cycles", highs, exp_highs);
        check("R4 strobe not on rise", mis_stb, 0);
        check("R4 back-to-back strobes", doubles, 0);
    endtask

    task automatic test_int_mode();
        int mis_stb = 0;
        int mis_clk = 0;
        int first = 0;
        do_reset();
        for (int j = 1; j <= 40 * N; j++) begin
            @(negedge clk);
            if (first == 0 && i_stb) first = j;
            if (i_stb != (((j - 1) % N) == 0)) mis_stb++;
            if (i_clk != (((j - 1) % N) < HI)) mis_clk++;
        end
        check("R5 first strobe edge", first, 1);
        check("R5 strobe spacing mismatches", mis_stb, 0);
        check("R6 duty mismatches", mis_clk, 0);
    endtask

    task automatic test_half();
        int mis_f = 0;
        int mis_i = 0;
        do_reset();
        for (int j = 1; j <= 200; j++) begin
            @(negedge clk);
            if (fh_clk != bit'(j % 2) || fh_stb != bit'(j % 2)) mis_f++;
            if (ih_clk != bit'(j % 2) || ih_stb != bit'(j % 2)) mis_i++;
        end
        check("R7 fractional half-rate mismatches", mis_f, 0);
        check("R7 integer half-rate mismatches", mis_i, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #5_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_frac_rate();
        test_frac_shape();
        test_int_mode();
        test_half();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule